// File: doc/BRIEF.md
# Delayed-Read Retry Controller for Bridged Target Regions

This block is the target-side controller for bus reads that land in bridged address regions, where the data comes from a slower local back-end. When a read arrives and no fetch is outstanding, the controller records the region and address and sends a one-cycle fetch request to the back-end. It then waits a bounded number of clocks for the back-end ready strobe. If the strobe comes within the window, the controller completes the read with target-ready and the fetched word. If it does not, the controller answers with a retry (stop). It keeps the pending region and address, and it latches the word when it arrives later.

While that fetch is outstanding, any read to a different bridged region is retried at once. A read to the pending region either collects the latched word at once or opens a fresh waiting window, and it issues no second fetch. The controller does not compare initiator or address on that reissue: whoever next hits the pending region receives the original word. Reads of the device's own operation registers bypass this tracking. They always complete on the next cycle with the register word. A bus data phase is modelled as a one-cycle `busReq` pulse. Each phase receives exactly one one-cycle response.

Top module: `pt_read_retry`

## Requirements
- R1: An access with `busIsPt` low completes on the cycle after `busReq` with `trdy` high, `stop` low and `rdData` equal to `regRdData`. This holds even while a bridged fetch is pending.
- R2: A bridged read with nothing pending raises `beReq` for exactly one cycle, on the cycle after `busReq`. At that cycle `beAddr` and `beRegion` carry the request's address and region.
- R3: When `beReady` is sampled high during the waiting window, `trdy` is high on the following cycle and `rdData` equals the `beData` sampled with it.
- R4: When `beReady` is not sampled on any of the WAIT_CLKS (default 16) edges after the request edge, `stop` is raised on the cycle after the last of them. The fetch then stays pending.
- R5: While a fetch is pending, a bridged read to any other region is answered with `stop` on the next cycle, and no `beReq` is raised.
- R6: A `beReady` that arrives while a fetch is pending but no window is open latches `beData`. The next read to the pending region then completes on the next cycle with that word and clears the pending state, so a later read to that region issues a new `beReq`.
- R7: A read to the pending region before the data has arrived raises no new `beReq`. It opens a fresh window of WAIT_CLKS clocks, and it completes as soon as `beReady` is sampled in that window.
- R8: The pending region is matched by region number alone. A read to it with a different address still receives the word fetched for the original request.
- R9: `trdy` and `stop` are never high together, and `devSel` is high whenever either of them is.
- R10: During and right after reset, `devSel`, `trdy`, `stop` and `beReq` are low and nothing is pending.
- R11: A `beReady` pulse while nothing is pending has no effect. A later read still fetches, waits and retries as normal, and it never returns the stray word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | One-cycle pulse that starts a read data phase |
| busIsPt | input | 1 | 1: bridged region, 0: operation register |
| busRegion | input | REGION_W | Bridged region number |
| busAddr | input | ADDR_W | Read address |
| regRdData | input | DATA_W | Operation register read word |
| beReq | output | 1 | One-cycle fetch request to the back-end |
| beRegion | output | REGION_W | Region of the pending fetch |
| beAddr | output | ADDR_W | Address of the pending fetch |
| beReady | input | 1 | Back-end completion strobe |
| beData | input | DATA_W | Back-end read word, valid with `beReady` |
| devSel | output | 1 | Response present |
| trdy | output | 1 | Read completed, `rdData` valid |
| stop | output | 1 | Retry requested |
| rdData | output | DATA_W | Read word returned to the bus |

## Verification
The bench drives `beReady` on the last edge of the window and also lets the window expire with no strobe. A counter that is off by one would either retry a read that should have completed or complete one that should have retried. It probes a stray strobe with nothing pending, and data that arrives between a retry and the reissue. A design that latches without a pending fetch would return the stray word, and one that drops late data would wait again instead of completing at once. Reads to other regions and to operation registers during a pending fetch catch a design that forgets the owning region, and one that retries register reads as well.

// File: rtl/pt_read_retry_pkg.sv
package pt_read_retry_pkg;

  // Strobes from the control FSM to the datapath, valid for one cycle.
  typedef struct packed {
    logic startFetch;  // record region/address, raise fetch request
    logic clearPend;   // drop pending fetch and latched word
    logic cntClr;      // restart the waiting window
    logic cntInc;      // advance the waiting window
    logic respDone;    // answer with target-ready
    logic respRetry;   // answer with stop
    logic useReg;      // completion takes the operation register word
  } ctlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctlState_t;

endpackage

// File: rtl/pt_read_retry_dp.sv
module pt_read_retry_dp
  import pt_read_retry_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REGION_W  = 2,
  parameter int WAIT_CLKS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strb,
  input  logic [REGION_W-1:0] busRegion,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   regRdData,
  input  logic                beReady,
  input  logic [DATA_W-1:0]   beData,
  output logic                pendValid,
  output logic [REGION_W-1:0] pendRegion,
  output logic                dataValid,
  output logic                cntAtLimit,
  output logic                beReq,
  output logic [ADDR_W-1:0]   beAddr,
  output logic [REGION_W-1:0] beRegion,
  output logic                devSel,
  output logic                trdy,
  output logic                stop,
  output logic [DATA_W-1:0]   rdData
);

  localparam int CNT_W = (WAIT_CLKS > 2) ? $clog2(WAIT_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CLKS - 1);

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] dataLatch;
  logic [CNT_W-1:0]  waitCnt;

  // Pending fetch record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendRegion <= '0;
      pendAddr   <= '0;
    end else if (strb.startFetch) begin
      pendValid  <= 1'b1;
      pendRegion <= busRegion;
      pendAddr   <= busAddr;
    end else if (strb.clearPend) begin
      pendValid  <= 1'b0;
    end
  end

  // Late data latch: only a strobe for an outstanding fetch is kept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      dataLatch <= '0;
    end else if (strb.clearPend) begin
      dataValid <= 1'b0;
    end else if (beReady && pendValid && !dataValid) begin
      dataValid <= 1'b1;
      dataLatch <= beData;
    end
  end

  // Waiting window counter, held at its last value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strb.cntClr) begin
      waitCnt <= '0;
    end else if (strb.cntInc && waitCnt != CNT_LAST) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign cntAtLimit = (waitCnt == CNT_LAST);

  // Bus response and fetch request registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beReq  <= 1'b0;
      devSel <= 1'b0;
      trdy   <= 1'b0;
      stop   <= 1'b0;
      rdData <= '0;
    end else begin
      beReq  <= strb.startFetch;
      devSel <= strb.respDone | strb.respRetry;
      trdy   <= strb.respDone;
      stop   <= strb.respRetry;
      if (strb.respDone) begin
        if (strb.useReg)     rdData <= regRdData;
        else if (dataValid)  rdData <= dataLatch;
        else                 rdData <= beData;
      end
    end
  end

  assign beAddr   = pendAddr;
  assign beRegion = pendRegion;

endmodule

// File: rtl/pt_read_retry_ctl.sv
module pt_read_retry_ctl
  import pt_read_retry_pkg::*;
#(
  parameter int REGION_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busIsPt,
  input  logic [REGION_W-1:0] busRegion,
  input  logic                beReady,
  input  logic                pendValid,
  input  logic [REGION_W-1:0] pendRegion,
  input  logic                dataValid,
  input  logic                cntAtLimit,
  output ctlStrobes_t         strb,
  output logic                waiting
);

  ctlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (busReq) begin
          if (!busIsPt) begin
            strb.respDone = 1'b1;
            strb.useReg   = 1'b1;
          end else if (pendValid && busRegion != pendRegion) begin
            strb.respRetry = 1'b1;
          end else if (pendValid) begin
            if (dataValid || beReady) begin
              strb.respDone  = 1'b1;
              strb.clearPend = 1'b1;
            end else begin
              strb.cntClr = 1'b1;
              nextState   = ST_WAIT;
            end
          end else begin
            strb.startFetch = 1'b1;
            strb.cntClr     = 1'b1;
            nextState       = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (beReady) begin
          strb.respDone  = 1'b1;
          strb.clearPend = 1'b1;
          nextState      = ST_IDLE;
        end else if (cntAtLimit) begin
          strb.respRetry = 1'b1;
          nextState      = ST_IDLE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign waiting = (state == ST_WAIT);

endmodule

// File: rtl/pt_read_retry.sv
module pt_read_retry
  import pt_read_retry_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REGION_W  = 2,
  parameter int WAIT_CLKS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busIsPt,
  input  logic [REGION_W-1:0] busRegion,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   regRdData,
  output logic                beReq,
  output logic [REGION_W-1:0] beRegion,
  output logic [ADDR_W-1:0]   beAddr,
  input  logic                beReady,
  input  logic [DATA_W-1:0]   beData,
  output logic                devSel,
  output logic                trdy,
  output logic                stop,
  output logic [DATA_W-1:0]   rdData
);

  ctlStrobes_t         strb;
  logic                waiting;
  logic                pendValid;
  logic [REGION_W-1:0] pendRegion;
  logic                dataValid;
  logic                cntAtLimit;

  pt_read_retry_ctl #(.REGION_W(REGION_W)) i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .busIsPt    (busIsPt),
    .busRegion  (busRegion),
    .beReady    (beReady),
    .pendValid  (pendValid),
    .pendRegion (pendRegion),
    .dataValid  (dataValid),
    .cntAtLimit (cntAtLimit),
    .strb       (strb),
    .waiting    (waiting)
  );

  pt_read_retry_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_W(REGION_W), .WAIT_CLKS(WAIT_CLKS)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busRegion  (busRegion),
    .busAddr    (busAddr),
    .regRdData  (regRdData),
    .beReady    (beReady),
    .beData     (beData),
    .pendValid  (pendValid),
    .pendRegion (pendRegion),
    .dataValid  (dataValid),
    .cntAtLimit (cntAtLimit),
    .beReq      (beReq),
    .beAddr     (beAddr),
    .beRegion   (beRegion),
    .devSel     (devSel),
    .trdy       (trdy),
    .stop       (stop),
    .rdData     (rdData)
  );

endmodule

// File: rtl/pt_read_retry_checker.sv
module pt_read_retry_checker #(
  parameter int REGION_W  = 2,
  parameter int WAIT_CLKS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                busReq,
  input logic                busIsPt,
  input logic [REGION_W-1:0] busRegion,
  input logic                beReq,
  input logic                beReady,
  input logic                devSel,
  input logic                trdy,
  input logic                stop,
  input logic                waiting,
  input logic                pendValid,
  input logic [REGION_W-1:0] pendRegion
);

  localparam int WC_W = $clog2(WAIT_CLKS + 2);

  // Counts edges spent in the waiting window, independent of the design counter
  logic [WC_W-1:0] chkCnt;
  always_ff @(posedge clk) begin
    if (!rstN)        chkCnt <= '0;
    else if (waiting) chkCnt <= chkCnt + 1'b1;
    else              chkCnt <= '0;
  end

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    trdy |-> !stop);

  assert_devsel_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trdy || stop) |-> devSel);

  assert_opreg_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busIsPt && !waiting) |=> (trdy && !stop));

  assert_other_region_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busIsPt && !waiting && pendValid && busRegion != pendRegion)
      |=> (stop && !beReq));

  assert_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stop && $past(waiting)) |-> (chkCnt == WC_W'(WAIT_CLKS)));

  assert_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    beReq |-> $past(busReq && busIsPt && !pendValid));

  assert_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && beReady) |=> trdy);

endmodule

bind pt_read_retry pt_read_retry_checker #(
  .REGION_W(REGION_W), .WAIT_CLKS(WAIT_CLKS)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busReq     (busReq),
  .busIsPt    (busIsPt),
  .busRegion  (busRegion),
  .beReq      (beReq),
  .beReady    (beReady),
  .devSel     (devSel),
  .trdy       (trdy),
  .stop       (stop),
  .waiting    (waiting),
  .pendValid  (pendValid),
  .pendRegion (pendRegion)
);

// File: tb/test_pt_read_retry.sv
module test_pt_read_retry;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int REGION_W = 2;
  localparam int WAIT_CLKS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0;
  logic busIsPt = 1'b0;
  logic [REGION_W-1:0] busRegion = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] regRdData = 32'h5EC0_0001;
  logic beReq;
  logic [REGION_W-1:0] beRegion;
  logic [ADDR_W-1:0] beAddr;
  logic beReady = 1'b0;
  logic [DATA_W-1:0] beData = '0;
  logic devSel, trdy, stop;
  logic [DATA_W-1:0] rdData;

  always #4 clk = ~clk;  // 125 MHz

  pt_read_retry #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_W(REGION_W), .WAIT_CLKS(WAIT_CLKS)
  ) i_pt_read_retry (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busIsPt(busIsPt),
    .busRegion(busRegion), .busAddr(busAddr), .regRdData(regRdData),
    .beReq(beReq), .beRegion(beRegion), .beAddr(beAddr),
    .beReady(beReady), .beData(beData),
    .devSel(devSel), .trdy(trdy), .stop(stop), .rdData(rdData)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          expCyc;
    bit          isRetry;
    logic [31:0] data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic pushExp(input int c, input bit r, input logic [31:0] d, input string tag);
    expItem_t it;
    it.expCyc = c; it.isRetry = r; it.data = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: pops one expectation for every response seen
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (trdy || stop) begin
        check(!(trdy && stop) && devSel, "R9 response encoding",
              {devSel, trdy, stop}, 3'b110);
      end
      if (devSel || trdy || stop) begin
        if (expQ.size() == 0) begin
          check(1'b0, "unexpected response", {devSel, trdy, stop}, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(cyc == it.expCyc, {it.tag, " cycle"}, cyc, it.expCyc);
          check(stop == it.isRetry && trdy == !it.isRetry, {it.tag, " kind"},
                {trdy, stop}, it.isRetry ? 2'b01 : 2'b10);
          if (!it.isRetry) check(rdData == it.data, {it.tag, " data"}, rdData, it.data);
        end
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input bit pt, input logic [1:0] rg, input logic [31:0] ad);
    busReq = 1'b1; busIsPt = pt; busRegion = rg; busAddr = ad;
    @(negedge clk);
    busReq = 1'b0;
  endtask

  task automatic ready(input logic [31:0] d);
    beReady = 1'b1; beData = d;
    @(negedge clk);
    beReady = 1'b0;
  endtask

  initial begin
    int c0;
    step(3);
    // R10 reset state
    check({devSel, trdy, stop, beReq} == 4'b0, "R10 outputs in reset",
          {devSel, trdy, stop, beReq}, 0);
    rstN = 1'b1;
    step(1);
    check({devSel, trdy, stop, beReq} == 4'b0, "R10 outputs after reset",
          {devSel, trdy, stop, beReq}, 0);

    // R1 operation register read
    c0 = cyc; pushExp(c0 + 1, 0, regRdData, "R1 op read");
    issue(0, 2'd0, 32'h40);
    step(1);

    // R2 + R3: fetch, ready inside the window
    c0 = cyc; pushExp(c0 + 5, 0, 32'hA1A1_0001, "R3 ready in window");
    issue(1, 2'd1, 32'h0000_1230);
    check(beReq == 1'b1, "R2 fetch request", beReq, 1);
    check(beAddr == 32'h0000_1230 && beRegion == 2'd1, "R2 fetch address",
          {beRegion, beAddr}, {2'd1, 32'h0000_1230});
    step(1);
    check(beReq == 1'b0, "R2 fetch request one cycle", beReq, 0);
    step(2);
    ready(32'hA1A1_0001);
    step(2);

    // R3 boundary: ready on the last edge of the window
    c0 = cyc; pushExp(c0 + 17, 0, 32'hB0B0_0016, "R3 ready on last edge");
    issue(1, 2'd2, 32'h0000_0080);
    step(15);
    ready(32'hB0B0_0016);
    step(2);

    // R4 timeout retry
    c0 = cyc; pushExp(c0 + 17, 1, '0, "R4 window expiry retry");
    issue(1, 2'd2, 32'h0000_2000);
    step(17);
    // R1 op read while pending
    c0 = cyc; regRdData = 32'h5EC0_0002;
    pushExp(c0 + 1, 0, 32'h5EC0_0002, "R1 op read while pending");
    issue(0, 2'd2, 32'h44);
    // R5 other region retried at once, no fetch
    c0 = cyc; pushExp(c0 + 1, 1, '0, "R5 other region retry");
    issue(1, 2'd0, 32'h0000_3000);
    check(beReq == 1'b0, "R5 no fetch for other region", beReq, 0);
    step(1);
    // R6 late data latched while idle, reissue completes at once
    ready(32'hC2C2_0002);
    step(2);
    c0 = cyc; pushExp(c0 + 1, 0, 32'hC2C2_0002, "R6 reissue with latched data");
    issue(1, 2'd2, 32'h0000_2000);
    check(beReq == 1'b0, "R6 reissue raises no fetch", beReq, 0);
    step(1);
    // R6 pending cleared: a new read fetches again
    c0 = cyc; pushExp(c0 + 3, 0, 32'hC2C2_0003, "R6 fresh fetch after delivery");
    issue(1, 2'd2, 32'h0000_2004);
    check(beReq == 1'b1, "R6 new fetch after clear", beReq, 1);
    step(1);
    ready(32'hC2C2_0003);
    step(2);

    // R7 reissue before data: new window, no fetch
    c0 = cyc; pushExp(c0 + 17, 1, '0, "R7 first retry");
    issue(1, 2'd3, 32'h0000_4000);
    step(17);
    c0 = cyc; pushExp(c0 + 3, 0, 32'hD3D3_0004, "R7 reissue completes in new window");
    issue(1, 2'd3, 32'h0000_4000);
    check(beReq == 1'b0, "R7 reissue raises no fetch", beReq, 0);
    step(1);
    ready(32'hD3D3_0004);
    step(2);
    c0 = cyc; pushExp(c0 + 17, 1, '0, "R7 second window full length");
    issue(1, 2'd3, 32'h0000_4100);
    step(17);
    c0 = cyc; pushExp(c0 + 17, 1, '0, "R7 reissue window expires again");
    issue(1, 2'd3, 32'h0000_4100);
    step(17);
    ready(32'hD3D3_0005);
    step(1);
    c0 = cyc; pushExp(c0 + 1, 0, 32'hD3D3_0005, "R7 collect after second window");
    issue(1, 2'd3, 32'h0000_4100);
    step(2);

    // R8 different address on pending region gets original word
    c0 = cyc; pushExp(c0 + 17, 1, '0, "R8 retry");
    issue(1, 2'd1, 32'h0000_5000);
    step(17);
    ready(32'hE4E4_0008);
    step(1);
    c0 = cyc; pushExp(c0 + 1, 0, 32'hE4E4_0008, "R8 other address gets original data");
    issue(1, 2'd1, 32'h0000_5FFC);
    step(2);

    // R11 stray ready with nothing pending
    ready(32'hBAD0_BAD0);
    step(2);
    c0 = cyc; pushExp(c0 + 17, 1, '0, "R11 stray ready ignored, window runs");
    issue(1, 2'd0, 32'h0000_6000);
    check(beReq == 1'b1, "R11 fetch still issued", beReq, 1);
    step(17);
    ready(32'hF5F5_0011);
    step(1);
    c0 = cyc; pushExp(c0 + 1, 0, 32'hF5F5_0011, "R11 real data, not stray");
    issue(1, 2'd0, 32'h0000_6000);
    step(3);

    check(expQ.size() == 0, "all expected responses seen", expQ.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule